// File: doc/BRIEF.md
# Decision-Tree Expression Evaluator

This block computes a single-bit Boolean function for an input vector. The function is held in an on-chip node table as a tree of typed decision nodes. A host first fills the table through a write port. Each node entry carries:

- the index of the variable it tests;
- a polarity bit;
- one of eight node kinds;
- a constant bit;
- two child references.

Inversion is never stored as extra nodes. It is kept as the per-node polarity bit, and the walker applies it as it goes.

To evaluate, the host presents a root index and a variable vector with a start pulse. The walker then visits one node per clock. At each node it either finishes with a value or moves to a child, and it keeps a running inversion bit. On completion it pulses `done`, and `result` and `err` hold the outcome until the next completion. A walk that tries to go deeper than the number of variables is cut off and flagged. Node writes and new start requests are ignored while a walk is running.

Top module: `dte_eval`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `result` and `err` are all 0.
- R2: A write with `wr_en` high while idle stores the following fields into the entry at `wr_addr`, and later walks use them:
  - variable index `wr_var`;
  - polarity `wr_pol` (1 = as stored, 0 = complemented);
  - kind `wr_kind`, encoded CONST=0, IDENT=1, ORNOT=2, AND=3, OR=4, ANDNOT=5, XORNOT=6, IF=7;
  - constant bit `wr_cval`;
  - child references `wr_c1` and `wr_c0`. Single-child kinds use `wr_c0`.
- R3: Timing of a walk:
  - A start accepted at clock edge E visits one node per cycle.
  - For a walk that visits k nodes, `busy` is high for k cycles.
  - `done` pulses for exactly one cycle after edge E+k, and at that point `busy` is low.
- R4: A CONST node ends the walk with its constant bit. An IDENT node ends the walk with the value v of its variable.
- R5: Early-exit kinds, where v is the value of the tested variable:
  - OR ends with 1 when v=1.
  - AND ends with 0 when v=0.
  - ORNOT ends with 1 when v=0.
  - ANDNOT ends with 0 when v=1.
  - Otherwise each of these moves to child 0.
- R6: An IF node moves to child 1 when v=1 and to child 0 when v=0.
- R7: An XORNOT node always moves to child 0. When v=0 it toggles the running inversion.
- R8: Every visited node with polarity 0 toggles the running inversion. `result` is the terminal value XOR the running inversion, including the terminating node's own polarity.
- R9: If the NVARS-th visited node does not terminate, the walk ends with `done`=1, `err`=1 and `result`=0. A walk that terminates within NVARS nodes reports `err`=0.
- R10: Writes to the node table are ignored while `busy` is high.
- R11: `start` is ignored while `busy` is high. The running walk completes unchanged.
- R12: `result` and `err` hold their values after `done` until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Node write strobe |
| wr_addr | input | IDX_W | Node entry to write |
| wr_var | input | VAR_W | Variable index tested by the node |
| wr_pol | input | 1 | Polarity: 1 as stored, 0 complemented |
| wr_kind | input | 3 | Node kind code |
| wr_cval | input | 1 | Constant value for CONST nodes |
| wr_c1 | input | IDX_W | Child taken by IF when v=1 |
| wr_c0 | input | IDX_W | Single child, or IF child for v=0 |
| start | input | 1 | Begin a walk (ignored while busy) |
| root | input | IDX_W | Root entry of the walk |
| vars | input | NVARS | Variable vector, captured at start |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Function value of the last walk |
| err | output | 1 | Last walk exceeded the depth bound |

## Verification
A walk over k nodes has `busy` high on the k cycles after the edge that accepts start. `done`, `result` and `err` appear after the k-th edge following acceptance. The bench computes k from its own model of the node table and checks `busy` and `done` on every one of those cycles, sampling on the falling edge. It checks the outcome exactly on the cycle where it is due. Writes and repeated start pulses are injected in the first busy cycle. Their lack of effect is then observed through the result of the running walk and of a later walk.

// File: rtl/dte_pkg.sv
package dte_pkg;
  typedef enum logic [2:0] {
    K_CONST  = 3'd0,
    K_IDENT  = 3'd1,
    K_ORNOT  = 3'd2,
    K_AND    = 3'd3,
    K_OR     = 3'd4,
    K_ANDNOT = 3'd5,
    K_XORNOT = 3'd6,
    K_IF     = 3'd7
  } kind_e;
endpackage

// File: rtl/dte_node_mem.sv
module dte_node_mem #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 24,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // single write port, registered read: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dte_node_step.sv
module dte_node_step
  import dte_pkg::*;
#(
  parameter int NVARS = 16,
  parameter int IDX_W = 8,
  localparam int VAR_W = (NVARS > 1) ? $clog2(NVARS) : 1
) (
  input  logic [VAR_W-1:0] n_var,
  input  logic             n_pol,
  input  logic [2:0]       n_kind,
  input  logic             n_cval,
  input  logic [IDX_W-1:0] n_c1,
  input  logic [IDX_W-1:0] n_c0,
  input  logic [NVARS-1:0] vars,
  input  logic             inv_in,
  output logic             term,
  output logic             term_val,
  output logic [IDX_W-1:0] next_idx,
  output logic             inv_out
);
  logic  v;
  logic  inv_node;
  logic  raw;
  kind_e kind;

  assign kind     = kind_e'(n_kind);
  assign v        = (32'(n_var) < NVARS) ? vars[n_var] : 1'b0;
  assign inv_node = inv_in ^ ~n_pol;

  always_comb begin
    term     = 1'b0;
    raw      = 1'b0;
    next_idx = n_c0;
    inv_out  = inv_node;
    unique case (kind)
      K_CONST:  begin term = 1'b1; raw = n_cval; end
      K_IDENT:  begin term = 1'b1; raw = v;      end
      K_OR:     if (v)  begin term = 1'b1; raw = 1'b1; end
      K_AND:    if (!v) begin term = 1'b1; raw = 1'b0; end
      K_ORNOT:  if (!v) begin term = 1'b1; raw = 1'b1; end
      K_ANDNOT: if (v)  begin term = 1'b1; raw = 1'b0; end
      K_XORNOT: inv_out = inv_node ^ ~v;
      K_IF:     next_idx = v ? n_c1 : n_c0;
      default:  ;
    endcase
    term_val = raw ^ inv_node;
  end
endmodule

// File: rtl/dte_walk_ctrl.sv
module dte_walk_ctrl #(
  parameter int NVARS = 16,
  localparam int SW = $clog2(NVARS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NVARS-1:0] vars_in,
  input  logic             term,
  input  logic             term_val,
  input  logic             inv_next,
  output logic             busy,
  output logic             done,
  output logic             result,
  output logic             err,
  output logic             inv,
  output logic [NVARS-1:0] vars_q
);
  logic [SW-1:0] steps;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= 1'b0;
      err    <= 1'b0;
      inv    <= 1'b0;
      steps  <= '0;
      vars_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          inv    <= 1'b0;
          steps  <= SW'(1);
          vars_q <= vars_in;
        end
      end else if (term) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= term_val;
        err    <= 1'b0;
      end else if (steps == SW'(NVARS)) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= 1'b0;
        err    <= 1'b1;
      end else begin
        inv   <= inv_next;
        steps <= steps + SW'(1);
      end
    end
  end
endmodule

// File: rtl/dte_eval.sv
module dte_eval #(
  parameter int NODES = 256,
  parameter int NVARS = 16,
  localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int VAR_W = (NVARS > 1) ? $clog2(NVARS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [VAR_W-1:0] wr_var,
  input  logic             wr_pol,
  input  logic [2:0]       wr_kind,
  input  logic             wr_cval,
  input  logic [IDX_W-1:0] wr_c1,
  input  logic [IDX_W-1:0] wr_c0,
  input  logic             start,
  input  logic [IDX_W-1:0] root,
  input  logic [NVARS-1:0] vars,
  output logic             busy,
  output logic             done,
  output logic             result,
  output logic             err
);
  localparam int NW = VAR_W + 5 + 2 * IDX_W;

  logic [NW-1:0]    wword;
  logic [NW-1:0]    rword;
  logic [IDX_W-1:0] rd_addr;
  logic [IDX_W-1:0] next_idx;
  logic [NVARS-1:0] vars_q;
  logic             inv;
  logic             inv_next;
  logic             term;
  logic             term_val;

  assign wword   = {wr_var, wr_pol, wr_kind, wr_cval, wr_c1, wr_c0};
  // fetch the root while idle, the chosen child while walking
  assign rd_addr = busy ? next_idx : root;

  dte_node_mem #(.DEPTH(NODES), .WIDTH(NW)) u_mem (
    .clk   (clk),
    .we    (wr_en & ~busy),
    .waddr (wr_addr),
    .wdata (wword),
    .raddr (rd_addr),
    .rdata (rword)
  );

  dte_node_step #(.NVARS(NVARS), .IDX_W(IDX_W)) u_step (
    .n_var    (rword[NW-1 -: VAR_W]),
    .n_pol    (rword[2*IDX_W+4]),
    .n_kind   (rword[2*IDX_W+1 +: 3]),
    .n_cval   (rword[2*IDX_W]),
    .n_c1     (rword[IDX_W +: IDX_W]),
    .n_c0     (rword[0 +: IDX_W]),
    .vars     (vars_q),
    .inv_in   (inv),
    .term     (term),
    .term_val (term_val),
    .next_idx (next_idx),
    .inv_out  (inv_next)
  );

  dte_walk_ctrl #(.NVARS(NVARS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .vars_in  (vars),
    .term     (term),
    .term_val (term_val),
    .inv_next (inv_next),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .err      (err),
    .inv      (inv),
    .vars_q   (vars_q)
  );
endmodule

// File: rtl/dte_eval_chk.sv
module dte_eval_chk #(
  parameter int NVARS = 16
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic result,
  input logic err
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= 0;
    else              run_len <= run_len + 1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy && !done && !err && !result));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_idle_r3:  assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  p_start_go_r3:   assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  p_walk_bound_r9: assert property (@(posedge clk) disable iff (rst) busy |-> (run_len < NVARS));
  p_err_zero_r9:   assert property (@(posedge clk) disable iff (rst) err |-> !result);
  p_hold_r12:      assert property (@(posedge clk) disable iff (rst)
                     !done |=> (done || ($stable(result) && $stable(err))));
endmodule

bind dte_eval dte_eval_chk #(.NVARS(NVARS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .done(done), .result(result), .err(err)
);

// File: tb/tb_dte_eval.sv
module tb_dte_eval;
  localparam int NODES = 16;
  localparam int NVARS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [1:0] wr_var = '0;
  logic       wr_pol = 1'b1;
  logic [2:0] wr_kind = '0;
  logic       wr_cval = 1'b0;
  logic [3:0] wr_c1 = '0;
  logic [3:0] wr_c0 = '0;
  logic       start = 1'b0;
  logic [3:0] root = '0;
  logic [3:0] vars = '0;
  logic       busy, done, result, err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int m_var[NODES], m_pol[NODES], m_kind[NODES], m_cval[NODES], m_c1[NODES], m_c0[NODES];

  always #2 clk = ~clk;

  dte_eval #(.NODES(NODES), .NVARS(NVARS)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_var(wr_var),
    .wr_pol(wr_pol), .wr_kind(wr_kind), .wr_cval(wr_cval), .wr_c1(wr_c1),
    .wr_c0(wr_c0), .start(start), .root(root), .vars(vars),
    .busy(busy), .done(done), .result(result), .err(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not end (actual cycles=%0d expected <100000)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // R2: writes one entry (kind codes: CONST0 IDENT1 ORNOT2 AND3 OR4 ANDNOT5 XORNOT6 IF7)
  task automatic put(input int a, input int vi, input int pol, input int kind,
                     input int cval, input int c1, input int c0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_var = 2'(vi); wr_pol = pol[0];
    wr_kind = 3'(kind); wr_cval = cval[0]; wr_c1 = 4'(c1); wr_c0 = 4'(c0);
    m_var[a] = vi; m_pol[a] = pol; m_kind[a] = kind; m_cval[a] = cval;
    m_c1[a] = c1; m_c0[a] = c0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic model(input int r, input logic [3:0] v, output int res, output int e, output int k);
    int cur = r;
    int inv = 0;
    int x;
    k = 0; e = 0; res = 0;
    forever begin
      k++;
      if (m_pol[cur] == 0) inv ^= 1;
      x = v[m_var[cur]];
      if (m_kind[cur] == 0) begin res = m_cval[cur] ^ inv; return; end
      if (m_kind[cur] == 1) begin res = x ^ inv; return; end
      if (m_kind[cur] == 4 && x == 1) begin res = 1 ^ inv; return; end
      if (m_kind[cur] == 3 && x == 0) begin res = inv; return; end
      if (m_kind[cur] == 2 && x == 0) begin res = 1 ^ inv; return; end
      if (m_kind[cur] == 5 && x == 1) begin res = inv; return; end
      if (k == NVARS) begin e = 1; res = 0; return; end
      if (m_kind[cur] == 6 && x == 0) inv ^= 1;
      cur = (m_kind[cur] == 7 && x == 1) ? m_c1[cur] : m_c0[cur];
    end
  endtask

  task automatic run_eval(input int r, input logic [3:0] v, input string req,
                          input bit wr_mid, input bit restart_mid);
    int eres, eerr, k;
    model(r, v, eres, eerr, k);
    @(negedge clk);
    root = 4'(r); vars = v; start = 1'b1;
    for (int i = 1; i <= k + 1; i++) begin
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      if (i <= k) begin
        check(busy === 1'b1, "R3 busy", int'(busy), 1);
        check(done === 1'b0, "R3 done early", int'(done), 0);
      end else begin
        check(done === 1'b1, "R3 done due", int'(done), 1);
        check(busy === 1'b0, "R3 busy after", int'(busy), 0);
        check(result === eres[0], req, int'(result), eres);
        check(err === eerr[0], "R9 err", int'(err), eerr);
      end
      if (i == 1 && wr_mid) begin
        // R10: overwrite entry 0 with a CONST 0 while walking
        wr_en = 1'b1; wr_addr = 4'd0; wr_var = 2'd0; wr_pol = 1'b1;
        wr_kind = 3'd0; wr_cval = 1'b0; wr_c1 = 4'd0; wr_c0 = 4'd0;
      end
      if (i == 1 && restart_mid) begin
        start = 1'b1; root = 4'd0; vars = 4'hF;
      end
    end
    start = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    int roots[9] = '{1, 2, 3, 4, 5, 6, 7, 8, 13};
    string tags[9] = '{"R4 ident", "R5 or", "R5 and", "R7 xornot", "R6 if",
                       "R8 ornot neg", "R5 andnot", "R8 neg ident", "R7 double"};
    logic held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(done === 1'b0, "R1 done", int'(done), 0);
    check(result === 1'b0, "R1 result", int'(result), 0);
    check(err === 1'b0, "R1 err", int'(err), 0);

    put(0, 0, 1, 0, 1, 0, 0);   // CONST 1
    put(1, 3, 1, 1, 0, 0, 0);   // IDENT x3
    put(2, 2, 1, 4, 0, 0, 1);   // OR x2 -> 1
    put(3, 1, 1, 3, 0, 0, 2);   // AND x1 -> 2
    put(4, 0, 1, 6, 0, 0, 1);   // XORNOT x0 -> 1
    put(5, 0, 1, 7, 0, 3, 2);   // IF x0 ? 3 : 2
    put(6, 1, 0, 2, 0, 0, 1);   // ORNOT x1 -> 1, complemented
    put(7, 2, 1, 5, 0, 0, 1);   // ANDNOT x2 -> 1
    put(8, 3, 0, 1, 0, 0, 0);   // IDENT x3, complemented
    put(9, 0, 1, 4, 0, 0, 10);  // OR chain, loops back
    put(10, 1, 1, 4, 0, 0, 11);
    put(11, 2, 1, 4, 0, 0, 12);
    put(12, 3, 1, 4, 0, 0, 9);
    put(13, 2, 0, 6, 0, 0, 4);  // XORNOT x2 -> 4, complemented

    run_eval(0, 4'h0, "R4 const", 1'b0, 1'b0);
    for (int ri = 0; ri < 9; ri++)
      for (int vv = 0; vv < 16; vv++)
        run_eval(roots[ri], 4'(vv), tags[ri], 1'b0, 1'b0);

    // R9: all-zero vars walk the OR chain past the bound; x2=1 ends on the third node
    run_eval(9, 4'h0, "R9 overflow", 1'b0, 1'b0);
    run_eval(9, 4'h4, "R9 in bound", 1'b0, 1'b0);

    // R10: write during a walk is dropped; entry 0 still yields 1
    run_eval(9, 4'h0, "R10 walk", 1'b1, 1'b0);
    run_eval(0, 4'h0, "R10 entry kept", 1'b0, 1'b0);

    // R11: restart during a walk is ignored (root 0 would give 1 in one node)
    run_eval(3, 4'b1010, "R11 walk", 1'b0, 1'b1);
    @(negedge clk);
    check(busy === 1'b0, "R11 no second walk", int'(busy), 0);

    // R12: hold after completion
    run_eval(8, 4'h0, "R8 neg ident", 1'b0, 1'b0);
    held = result;
    repeat (3) begin
      @(negedge clk);
      check(done === 1'b0, "R12 done pulse", int'(done), 0);
      check(result === held, "R12 hold", int'(result), int'(held));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule